// File: doc/BRIEF.md
# Two-Stage Min/Max Combine Unit

This unit is a pipelined integer operation with three 32-bit operands, A, B and C. The first stage picks the larger or the smaller of A and B. The comparison is signed or unsigned, and A and B always share one signedness.

The second stage combines that intermediate value with C. The choices are:

- write the intermediate value into a halfword or a byte of C;
- add it to C;
- compare it with C again, under a signedness of its own;
- pass it through unchanged.

This lets one operation act as a three-input minimum or maximum, a clamp, or a packing step.

Operands and control arrive on a valid/ready handshake. The result leaves on a valid/ready pair. There is one register stage after the first compare and one after the combine, so a result appears two cycles after it is accepted. A new operation can enter every cycle while the consumer is ready.

Top module: `minmax_combine_unit`

## Requirements
- R1: When `in_take_max` is 1 the intermediate value is the larger of A and B. When it is 0 the intermediate value is the smaller of the two.
- R2: The first-stage compare treats A and B as two's-complement numbers when `in_src_signed` is 1, and as unsigned numbers when it is 0.
- R3: Combine code 0 returns the intermediate value's low 16 bits in result bits [31:16], with C[15:0] in result bits [15:0].
- R4: Combine code 1 returns C[31:16] in result bits [31:16], with the intermediate value's low 16 bits in result bits [15:0].
- R5: Combine code 2 replaces C[7:0] with the intermediate value's low byte. Combine code 3 replaces C[23:16] with the intermediate value's low byte. Every other bit of C passes through to the result.
- R6: Combine code 4 returns the intermediate value plus C, wrapped modulo 2^32.
- R7: Combine codes 5 and 6 return the minimum and the maximum, respectively, of the intermediate value and C. This compare is signed when `in_dst_signed` is 1, independently of `in_src_signed`.
- R8: Combine code 7 returns the intermediate value, whatever the value of C.
- R9: A result is presented on the output two clock edges after it is accepted. With `out_ready` held at 1, one operation is accepted and one result is delivered every cycle.
- R10: While `out_valid` is 1 and `out_ready` is 0, the result is held stable. Every accepted operation is delivered exactly once, in order.
- R11: While reset is asserted, and on the first cycle after it, `out_valid` is 0 and no operation in flight survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and control are present |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_a | input | 32 | First compare operand |
| in_b | input | 32 | Second compare operand |
| in_c | input | 32 | Combine operand |
| in_take_max | input | 1 | 1 selects the larger of A and B, 0 the smaller |
| in_src_signed | input | 1 | Signedness of the A/B compare |
| in_dst_signed | input | 1 | Signedness of the second-stage compare |
| in_combine_op | input | 3 | Combine code 0..7 (see R3 to R8) |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 32 | Combined result |

## Verification
The A/B pairs are chosen at the sign boundary: 0x80000000 against 0x7FFFFFFF, and 0xFFFFFFFF against 0. Running each pair with the signed and then the unsigned setting shows whether the first-stage compare honours `in_src_signed`, because the winner flips between the two.

The merge vectors use recognisable byte patterns in C, so a misplaced field or a clobbered neighbour shows up directly.

The second-stage minimum and maximum are run against C values of 0x80000000 and 0xFFFFFFFF, under both destination signednesses. This separates `in_dst_signed` from `in_src_signed`.

A back-to-back stream checks single-cycle throughput and the two-cycle latency. A long pseudo-random stream with random output stalls checks ordering, hold-while-stalled and that nothing is lost, against an independent model.

// File: rtl/mmx_pkg.sv
package mmx_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        CMB_HI16  = 3'd0,
        CMB_LO16  = 3'd1,
        CMB_BYTE0 = 3'd2,
        CMB_BYTE2 = 3'd3,
        CMB_ADD   = 3'd4,
        CMB_MIN   = 3'd5,
        CMB_MAX   = 3'd6,
        CMB_PASS  = 3'd7
    } cmb_op_e;

endpackage

// File: rtl/mmx_select_stage.sv
module mmx_select_stage
    import mmx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_a,
    input  logic [W-1:0] in_b,
    input  logic [W-1:0] in_c,
    input  logic         in_take_max,
    input  logic         in_src_signed,
    input  logic         in_dst_signed,
    input  cmb_op_e      in_op,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_mid,
    output logic [W-1:0] out_c,
    output cmb_op_e      out_op,
    output logic         out_dst_signed
);

    typedef struct packed {
        logic         valid;
        logic [W-1:0] mid;
        logic [W-1:0] c;
        cmb_op_e      op;
        logic         dst_signed;
    } sel_state_t;

    sel_state_t st_d, st_q;
    logic       a_below_b;
    logic [W-1:0] winner;

    always_comb begin
        if (in_src_signed) a_below_b = $signed(in_a) < $signed(in_b);
        else               a_below_b = in_a < in_b;

        if (in_take_max) winner = a_below_b ? in_b : in_a;
        else             winner = a_below_b ? in_a : in_b;

        in_ready = !st_q.valid || out_ready;

        st_d = st_q;
        if (in_ready) begin
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.mid        = winner;
                st_d.c          = in_c;
                st_d.op         = in_op;
                st_d.dst_signed = in_dst_signed;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid      = st_q.valid;
    assign out_mid        = st_q.mid;
    assign out_c          = st_q.c;
    assign out_op         = st_q.op;
    assign out_dst_signed = st_q.dst_signed;

    // R1
    mid_from_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (out_mid == $past(in_a) || out_mid == $past(in_b)));

    // R2
    unsigned_max_ge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_take_max && !in_src_signed)
            |=> (out_mid >= $past(in_a) && out_mid >= $past(in_b)));

    // R2
    signed_min_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !in_take_max && in_src_signed)
            |=> ($signed(out_mid) <= $signed($past(in_a)) &&
                 $signed(out_mid) <= $signed($past(in_b))));

endmodule

// File: rtl/mmx_merge_stage.sv
module mmx_merge_stage
    import mmx_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_mid,
    input  logic [W-1:0] in_c,
    input  cmb_op_e      in_op,
    input  logic         in_dst_signed,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_result
);

    localparam int unsigned HALF_W = W / 2;
    localparam int unsigned HB_LSB = HALF_W;
    localparam int unsigned HB_MSB = HALF_W + BYTE_W - 1;

    typedef struct packed {
        logic         valid;
        logic [W-1:0] result;
    } mrg_state_t;

    mrg_state_t   st_d, st_q;
    logic         mid_below_c;
    logic [W-1:0] combined;

    always_comb begin
        if (in_dst_signed) mid_below_c = $signed(in_mid) < $signed(in_c);
        else               mid_below_c = in_mid < in_c;

        combined = in_c;
        unique case (in_op)
            CMB_HI16:  combined[W-1:HALF_W]         = in_mid[HALF_W-1:0];
            CMB_LO16:  combined[HALF_W-1:0]         = in_mid[HALF_W-1:0];
            CMB_BYTE0: combined[BYTE_W-1:0]         = in_mid[BYTE_W-1:0];
            CMB_BYTE2: combined[HB_MSB:HB_LSB]      = in_mid[BYTE_W-1:0];
            CMB_ADD:   combined = in_mid + in_c;
            CMB_MIN:   combined = mid_below_c ? in_mid : in_c;
            CMB_MAX:   combined = mid_below_c ? in_c : in_mid;
            CMB_PASS:  combined = in_mid;
            default:   combined = in_mid;
        endcase

        in_ready = !st_q.valid || out_ready;

        st_d = st_q;
        if (in_ready) begin
            st_d.valid = in_valid;
            if (in_valid) st_d.result = combined;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;

    // R4
    lo16_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == CMB_LO16)
            |=> out_result[W-1:HALF_W] == $past(in_c[W-1:HALF_W]));

    // R5
    byte0_keeps_c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == CMB_BYTE0)
            |=> out_result[W-1:BYTE_W] == $past(in_c[W-1:BYTE_W]));

    // R8
    pass_is_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == CMB_PASS) |=> out_result == $past(in_mid));

endmodule

// File: rtl/minmax_combine_unit.sv
module minmax_combine_unit
    import mmx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [31:0] in_a,
    input  logic [31:0] in_b,
    input  logic [31:0] in_c,
    input  logic        in_take_max,
    input  logic        in_src_signed,
    input  logic        in_dst_signed,
    input  logic [2:0]  in_combine_op,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_result
);

    localparam int unsigned DATA_W = 32;

    logic              s1_valid;
    logic              s2_ready;
    logic [DATA_W-1:0] s1_mid;
    logic [DATA_W-1:0] s1_c;
    cmb_op_e           s1_op;
    logic              s1_dst_signed;

    mmx_select_stage #(.W(DATA_W)) u_select (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_a           (in_a),
        .in_b           (in_b),
        .in_c           (in_c),
        .in_take_max    (in_take_max),
        .in_src_signed  (in_src_signed),
        .in_dst_signed  (in_dst_signed),
        .in_op          (cmb_op_e'(in_combine_op)),
        .out_valid      (s1_valid),
        .out_ready      (s2_ready),
        .out_mid        (s1_mid),
        .out_c          (s1_c),
        .out_op         (s1_op),
        .out_dst_signed (s1_dst_signed)
    );

    mmx_merge_stage #(.W(DATA_W)) u_merge (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (s1_valid),
        .in_ready      (s2_ready),
        .in_mid        (s1_mid),
        .in_c          (s1_c),
        .in_op         (s1_op),
        .in_dst_signed (s1_dst_signed),
        .out_valid     (out_valid),
        .out_ready     (out_ready),
        .out_result    (out_result)
    );

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

    // R10
    full_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && s1_valid) |-> !in_ready);

    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && !s1_valid));

endmodule

// File: tb/minmax_combine_unit_test.sv
module minmax_combine_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic [31:0] in_c = '0;
    logic        in_take_max = 1'b0;
    logic        in_src_signed = 1'b0;
    logic        in_dst_signed = 1'b0;
    logic [2:0]  in_combine_op = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_result;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    minmax_combine_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_take_max(in_take_max),
        .in_src_signed(in_src_signed), .in_dst_signed(in_dst_signed),
        .in_combine_op(in_combine_op), .out_valid(out_valid),
        .out_ready(out_ready), .out_result(out_result)
    );

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        logic        mx;
        logic        ss;
        logic        ds;
        logic [2:0]  op;
        logic [31:0] exp;
    } vec_t;

    localparam int NVEC = 18;
    localparam vec_t VECS [NVEC] = '{
        '{32'h00000005, 32'h00000009, 32'hDEADBEEF, 1'b1, 1'b0, 1'b0, 3'd7, 32'h00000009},
        '{32'h00000005, 32'h00000009, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 3'd7, 32'h00000005},
        '{32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b1, 1'b0, 3'd7, 32'h7FFFFFFF},
        '{32'h80000000, 32'h7FFFFFFF, 32'h00000000, 1'b1, 1'b0, 1'b0, 3'd7, 32'h80000000},
        '{32'hFFFFFFFF, 32'h00000000, 32'h12345678, 1'b0, 1'b1, 1'b0, 3'd7, 32'hFFFFFFFF},
        '{32'hFFFFFFFF, 32'h00000000, 32'h12345678, 1'b0, 1'b0, 1'b0, 3'd7, 32'h00000000},
        '{32'h12345678, 32'h00000001, 32'hAAAABBBB, 1'b1, 1'b0, 1'b0, 3'd0, 32'h5678BBBB},
        '{32'h12345678, 32'h00000001, 32'hAAAABBBB, 1'b1, 1'b0, 1'b0, 3'd1, 32'hAAAA5678},
        '{32'h12345678, 32'h00000001, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 3'd2, 32'hAABBCC78},
        '{32'h12345678, 32'h00000001, 32'hAABBCCDD, 1'b1, 1'b0, 1'b0, 3'd3, 32'hAA78CCDD},
        '{32'hFFFFFFFF, 32'h00000000, 32'h00000002, 1'b1, 1'b0, 1'b0, 3'd4, 32'h00000001},
        '{32'h00000007, 32'h00000003, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b0, 3'd4, 32'h80000002},
        '{32'h00000003, 32'h00000001, 32'h80000000, 1'b1, 1'b0, 1'b1, 3'd5, 32'h80000000},
        '{32'h00000003, 32'h00000001, 32'h80000000, 1'b1, 1'b0, 1'b0, 3'd5, 32'h00000003},
        '{32'h00000003, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 3'd6, 32'h00000003},
        '{32'h00000003, 32'h00000001, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 3'd6, 32'hFFFFFFFF},
        '{32'h0000000A, 32'h00000014, 32'h00000004, 1'b0, 1'b0, 1'b0, 3'd5, 32'h00000004},
        '{32'h00000001, 32'h00000002, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b0, 3'd7, 32'h00000002}
    };

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2, 3'd3: return "R5";
            3'd4: return "R6";
            3'd5, 3'd6: return "R7";
            default: return "R1 R2 R8";
        endcase
    endfunction

    function automatic logic lt(input logic [31:0] x, input logic [31:0] y,
                                input logic sgn);
        if (sgn) return (x[31] != y[31]) ? x[31] : (x < y);
        return x < y;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                          input logic [31:0] c, input logic mx,
                                          input logic ss, input logic ds,
                                          input logic [2:0] op);
        logic [31:0] m;
        if (mx) m = lt(a, b, ss) ? b : a;
        else    m = lt(a, b, ss) ? a : b;
        case (op)
            3'd0: return {m[15:0], c[15:0]};
            3'd1: return {c[31:16], m[15:0]};
            3'd2: return {c[31:8], m[7:0]};
            3'd3: return {c[31:24], m[7:0], c[15:0]};
            3'd4: return m + c;
            3'd5: return lt(m, c, ds) ? m : c;
            3'd6: return lt(m, c, ds) ? c : m;
            default: return m;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        in_valid      = vld;
        in_a          = v.a;
        in_b          = v.b;
        in_c          = v.c;
        in_take_max   = v.mx;
        in_src_signed = v.ss;
        in_dst_signed = v.ds;
        in_combine_op = v.op;
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    function automatic logic [31:0] pick(input logic [2:0] sel, input logic [31:0] rnd);
        case (sel)
            3'd0: return 32'h00000000;
            3'd1: return 32'h7FFFFFFF;
            3'd2: return 32'h80000000;
            3'd3: return 32'hFFFFFFFF;
            default: return rnd;
        endcase
    endfunction

    initial begin
        logic [31:0] lfsr;
        logic [31:0] exp_q[$];
        logic        hold_pending;
        logic [31:0] hold_val;
        int          sent;
        int          got;
        vec_t        rv;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        check("R11", {31'd0, in_ready}, 32'd1);

        // Table walk, one vector at a time: latency and function
        for (int i = 0; i < NVEC; i++) begin
            drive(VECS[i], 1'b1);
            @(negedge clk);
            in_valid = 1'b0;
            // R9: not yet visible after one edge
            check("R9", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
            check("R9", {31'd0, out_valid}, 32'd1);
            check(tag_of(VECS[i].op), out_result, VECS[i].exp);
        end
        @(negedge clk);

        // R9: back-to-back stream, one result per cycle
        for (int n = 0; n < NVEC + 2; n++) begin
            if (n >= 2) begin
                check("R9", {31'd0, out_valid}, 32'd1);
                check(tag_of(VECS[n-2].op), out_result, VECS[n-2].exp);
            end
            if (n < NVEC) begin
                check("R9", {31'd0, in_ready}, 32'd1);
                drive(VECS[n], 1'b1);
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R10: random operands with random output stalls
        lfsr = 32'h1ACE5EED;
        sent = 0;
        got = 0;
        hold_pending = 1'b0;
        hold_val = '0;
        for (int cyc = 0; cyc < 1200; cyc++) begin
            if (hold_pending) begin
                check("R10", {31'd0, out_valid}, 32'd1);
                check("R10", out_result, hold_val);
            end
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            out_ready = lfsr[0] | lfsr[3];
            rv.a  = pick(lfsr[6:4], lfsr * 32'd2654435761);
            rv.b  = pick(lfsr[9:7], {lfsr[15:0], lfsr[31:16]});
            rv.c  = pick(lfsr[12:10], ~lfsr);
            rv.mx = lfsr[13];
            rv.ss = lfsr[14];
            rv.ds = lfsr[15];
            rv.op = lfsr[18:16];
            rv.exp = '0;
            drive(rv, (sent < 300) && lfsr[20]);
            #1;
            if (in_valid && in_ready) begin
                exp_q.push_back(model(rv.a, rv.b, rv.c, rv.mx, rv.ss, rv.ds, rv.op));
                sent++;
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check("R10", 32'd1, 32'd0);
                end else begin
                    check("R10", out_result, exp_q.pop_front());
                end
                got++;
            end
            hold_pending = out_valid && !out_ready;
            hold_val = out_result;
            @(negedge clk);
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (3) @(negedge clk);
        check("R10", got, sent);
        check("R10", sent, 32'd300);

        // R11: reset with operations in flight
        drive(VECS[0], 1'b1);
        @(negedge clk);
        drive(VECS[1], 1'b1);
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        check("R11", {31'd0, out_valid}, 32'd0);
        check("R11", {31'd0, in_ready}, 32'd1);

        finish_run();
    end

endmodule